// File: doc/BRIEF.md
# Triggered ADC scan sequencer

This block controls an external successive-approximation conversion engine in a one-shot scan mode that waits for a hardware trigger. Software sets an enable bit to bring the block from stop into trigger standby. Each accepted trigger, or a software write of 1 to the start/busy bit, raises busy. The block then lets the converter supply settle for a programmable number of cycles and converts the four channels of the selected group once, in ascending order. Each finished conversion is copied into a result register and announced with a one-cycle interrupt pulse. After the fourth channel, busy clears by itself and the block waits for the next trigger.

A scan can be disturbed while it runs. A new trigger, a start-bit write of 1 or any write to the group select field restarts the scan at the group's first channel. The partial conversion is dropped and a fresh settling wait follows. A start-bit write of 0, or clearing the enable bit, aborts the scan and returns to standby. When a conversion is outstanding at an abort, the engine gets a one-cycle cancel pulse, and a completion that belongs to a dropped conversion is never stored.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, enable, busy, group, result, irq, eng_start and eng_cancel are all 0.
- R2: While enable is 0, hw_trig pulses and start writes of 1 are ignored: busy stays 0 and eng_start is never asserted.
- R3: Writing enable to 1 puts the block in standby with busy 0. No conversion starts until a trigger or a start write of 1 arrives. A trigger in the same cycle as the enable write is ignored.
- R4: A launch sampled at a clock edge raises busy after that edge. eng_start is first high in the SETTLE_CYCLES+1-th cycle after the launch cycle.
- R5: A scan drives eng_chan with {group, index}, index 0 to 3 in order. Group 0 selects channels 0-3 and group 1 selects channels 4-7. eng_start is a one-cycle pulse, and the next channel starts in the cycle after the previous done is accepted.
- R6: Each accepted eng_done loads eng_result into result and pulses irq for one cycle, both in the cycle after done. A complete scan gives exactly four irq pulses, and result holds its value otherwise.
- R7: After the fourth accepted done, busy clears and the block waits in standby. A later trigger starts a complete new scan.
- R8: A trigger during a scan restarts it at index 0 with a full settling wait. If a conversion was outstanding, eng_cancel pulses in the next cycle and that conversion produces no result and no irq.
- R9: A group write during a scan restarts the scan at the first channel of the written group, even when the value is unchanged. A group write while idle only updates group.
- R10: A start write of 1 restarts a running scan at index 0. While idle with enable 1, it launches a scan exactly like a trigger.
- R11: A start write of 0 during a scan clears busy at the next edge, with eng_cancel if a conversion was outstanding. No further result is produced until a new launch.
- R12: Writing enable to 0 clears enable and aborts a running scan like R11. Triggers are then ignored.
- R13: Priority within one cycle: an abort (start 0 or enable 0) beats a launch, and any restart or abort beats a coincident eng_done, which is then discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_wdata | input | 1 | Enable value written |
| start_wr | input | 1 | Write strobe for the start/busy bit |
| start_wdata | input | 1 | Start value written (1 launch/restart, 0 abort) |
| grp_wr | input | 1 | Write strobe for the group select field |
| grp_wdata | input | 1 | Group value written (0: channels 0-3, 1: channels 4-7) |
| hw_trig | input | 1 | Hardware trigger pulse |
| enable | output | 1 | Current enable bit |
| busy | output | 1 | Start/busy bit, high while a scan runs |
| group | output | 1 | Current group select |
| eng_start | output | 1 | One-cycle conversion start to the engine |
| eng_chan | output | 3 | Channel number for the conversion |
| eng_cancel | output | 1 | One-cycle cancel of the outstanding conversion |
| eng_done | input | 1 | One-cycle completion from the engine |
| eng_result | input | 10 | Conversion result, valid with eng_done |
| result | output | 10 | Result register |
| irq | output | 1 | One-cycle end-of-conversion interrupt |

## Verification
The two functions that can meet in one cycle are the completion of a channel and a restart request. The bench provokes this by timing a trigger to land in exactly the cycle in which the engine model raises eng_done for the second channel of a scan. The collision is judged correct when that channel's result never reaches the result register and no irq is raised for it. The scan must then restart from the first channel and deliver exactly four further results. A second collision, a start write of 0 together with a trigger, must leave busy low.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int SCAN_LEN = 4;
    localparam int IDX_W    = $clog2(SCAN_LEN);
    localparam int GRP_W    = 1;
    localparam int CHAN_W   = GRP_W + IDX_W;

    typedef enum logic [1:0] {
        SEQ_STOP   = 2'd0,
        SEQ_SETTLE = 2'd1,
        SEQ_CONV   = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic halt;
        logic relaunch;
        logic accept;
    } seq_evt_t;

    function automatic logic [CHAN_W-1:0] chan_of(input logic [GRP_W-1:0] grp,
                                                  input logic [IDX_W-1:0] idx);
        return {grp, idx};
    endfunction

endpackage

// File: rtl/adc_settle_timer.sv
module adc_settle_timer #(
    parameter int SETTLE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load_full,
    input  logic load_none,
    output logic expired
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load_full) begin
            cnt <= CNT_W'(SETTLE_CYCLES);
        end else if (load_none) begin
            cnt <= '0;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    // R4: the settling count never exceeds its programmed length
    p_count_bound_r4: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(SETTLE_CYCLES));

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_wr,
    input  logic              en_wdata,
    input  logic              start_wr,
    input  logic              start_wdata,
    input  logic              grp_wr,
    input  logic [GRP_W-1:0]  grp_wdata,
    input  logic              hw_trig,
    input  logic              eng_done,
    input  logic              timer_expired,
    output logic              timer_load_full,
    output logic              timer_load_none,
    output logic              enable_q,
    output logic              busy,
    output logic [GRP_W-1:0]  group_q,
    output logic              eng_start,
    output logic [CHAN_W-1:0] eng_chan,
    output logic              eng_cancel,
    output logic              accept
);
    seq_state_e       state;
    logic [IDX_W-1:0] idx;
    logic             cancel_q;
    logic             go;
    logic             last;
    seq_evt_t         evt;

    always_comb begin
        // launch source: trigger or start write of 1, only when enabled
        go           = enable_q & (hw_trig | (start_wr & start_wdata));
        evt.halt     = (start_wr & ~start_wdata) | (en_wr & ~en_wdata);
        evt.relaunch = go | ((state != SEQ_STOP) & grp_wr);
        evt.accept   = (state == SEQ_CONV) & eng_done & ~evt.halt & ~evt.relaunch;
        last         = (idx == IDX_W'(SCAN_LEN - 1));
    end

    assign busy            = (state != SEQ_STOP);
    assign accept          = evt.accept;
    assign eng_start       = (state == SEQ_SETTLE) & timer_expired & ~evt.halt & ~evt.relaunch;
    assign eng_chan        = chan_of(group_q, idx);
    assign eng_cancel      = cancel_q;
    assign timer_load_full = ~evt.halt & evt.relaunch;
    assign timer_load_none = evt.accept & ~last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_STOP;
            idx      <= '0;
            enable_q <= 1'b0;
            group_q  <= '0;
            cancel_q <= 1'b0;
        end else begin
            if (en_wr) begin
                enable_q <= en_wdata;
            end
            if (grp_wr) begin
                group_q <= grp_wdata;
            end
            cancel_q <= (state == SEQ_CONV) & (evt.halt | evt.relaunch);
            if (evt.halt) begin
                state <= SEQ_STOP;
                idx   <= '0;
            end else if (evt.relaunch) begin
                state <= SEQ_SETTLE;
                idx   <= '0;
            end else if (evt.accept) begin
                if (last) begin
                    state <= SEQ_STOP;
                    idx   <= '0;
                end else begin
                    state <= SEQ_SETTLE;
                    idx   <= idx + 1'b1;
                end
            end else if (eng_start) begin
                state <= SEQ_CONV;
            end
        end
    end

    // R4: a freshly raised busy never coincides with a conversion start
    p_settle_first_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !eng_start);

    // R5: conversion starts are single-cycle pulses
    p_start_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);

    // R2: an idle, disabled block stays idle
    p_disabled_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (!enable_q && state == SEQ_STOP) |=> state == SEQ_STOP);

    // R12: with enable cleared no scan is running
    p_no_scan_disabled_r12: assert property (@(posedge clk) disable iff (rst)
        !enable_q |-> !busy);

endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [RES_W-1:0] din,
    output logic [RES_W-1:0] result_q,
    output logic             irq_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= load;
            if (load) begin
                result_q <= din;
            end
        end
    end

    // R6: the result register only changes together with an interrupt
    p_result_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !irq_q |-> $stable(result_q));

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int SETTLE_CYCLES = 8,
    parameter int RES_W         = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_wr,
    input  logic              en_wdata,
    input  logic              start_wr,
    input  logic              start_wdata,
    input  logic              grp_wr,
    input  logic [GRP_W-1:0]  grp_wdata,
    input  logic              hw_trig,
    output logic              enable,
    output logic              busy,
    output logic [GRP_W-1:0]  group,
    output logic              eng_start,
    output logic [CHAN_W-1:0] eng_chan,
    output logic              eng_cancel,
    input  logic              eng_done,
    input  logic [RES_W-1:0]  eng_result,
    output logic [RES_W-1:0]  result,
    output logic              irq
);
    logic timer_expired;
    logic timer_load_full;
    logic timer_load_none;
    logic accept;

    adc_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .load_full (timer_load_full),
        .load_none (timer_load_none),
        .expired   (timer_expired)
    );

    adc_scan_ctrl u_ctrl (
        .clk             (clk),
        .rst             (rst),
        .en_wr           (en_wr),
        .en_wdata        (en_wdata),
        .start_wr        (start_wr),
        .start_wdata     (start_wdata),
        .grp_wr          (grp_wr),
        .grp_wdata       (grp_wdata),
        .hw_trig         (hw_trig),
        .eng_done        (eng_done),
        .timer_expired   (timer_expired),
        .timer_load_full (timer_load_full),
        .timer_load_none (timer_load_none),
        .enable_q        (enable),
        .busy            (busy),
        .group_q         (group),
        .eng_start       (eng_start),
        .eng_chan        (eng_chan),
        .eng_cancel      (eng_cancel),
        .accept          (accept)
    );

    adc_result_reg #(.RES_W(RES_W)) u_res (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .din      (eng_result),
        .result_q (result),
        .irq_q    (irq)
    );

    // R6: every interrupt follows an engine completion
    p_irq_after_done_r6: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(eng_done));

    // R13: a cancelled conversion never also yields an interrupt
    p_cancel_no_irq_r13: assert property (@(posedge clk) disable iff (rst)
        eng_cancel |-> !irq);

endmodule

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;
    localparam int SET = 6;
    localparam int LAT = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_wr = 0, en_wdata = 0, start_wr = 0, start_wdata = 0;
    logic       grp_wr = 0, grp_wdata = 0, hw_trig = 0;
    logic       enable, busy, group, eng_start, eng_cancel, irq;
    logic [2:0] eng_chan;
    logic       eng_done = 0;
    logic [9:0] eng_result = '0;
    logic [9:0] result;

    int checks = 0, errors = 0;
    int log_chan [64];
    int log_n = 0;
    int cancel_n = 0;
    bit finished = 0;

    // engine model state
    bit       m_pend = 0;
    int       m_cnt = 0;
    logic [2:0] m_chan = '0;
    logic [6:0] m_id = '0;

    always #5 clk = ~clk;

    adc_scan_seq #(.SETTLE_CYCLES(SET), .RES_W(10)) uut (
        .clk(clk), .rst(rst),
        .en_wr(en_wr), .en_wdata(en_wdata),
        .start_wr(start_wr), .start_wdata(start_wdata),
        .grp_wr(grp_wr), .grp_wdata(grp_wdata),
        .hw_trig(hw_trig),
        .enable(enable), .busy(busy), .group(group),
        .eng_start(eng_start), .eng_chan(eng_chan), .eng_cancel(eng_cancel),
        .eng_done(eng_done), .eng_result(eng_result),
        .result(result), .irq(irq)
    );

    // conversion engine model: fixed latency, result = {id, channel}
    always @(negedge clk) begin
        eng_done = 1'b0;
        if (eng_cancel) m_pend = 0;
        if (m_pend) begin
            m_cnt = m_cnt - 1;
            if (m_cnt == 0) begin
                eng_done   = 1'b1;
                eng_result = {m_id, m_chan};
                m_pend     = 0;
            end
        end
        if (eng_start) begin
            m_pend = 1;
            m_cnt  = LAT;
            m_chan = eng_chan;
            m_id   = m_id + 1'b1;
        end
    end

    // monitor of interrupts and cancels
    always @(negedge clk) begin
        if (irq && log_n < 64) begin
            log_chan[log_n] = int'(result[2:0]);
            log_n = log_n + 1;
        end
        if (eng_cancel) cancel_n = cancel_n + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_log(input string req, input int n, input int exp [8]);
        chk(log_n == n, {req, " result count"}, log_n, n);
        for (int i = 0; i < n && i < log_n; i++)
            chk(log_chan[i] == exp[i], {req, " channel order"}, log_chan[i], exp[i]);
    endtask

    task automatic clear_log();
        @(negedge clk);
        log_n = 0;
        cancel_n = 0;
    endtask

    task automatic pulse_trig();
        hw_trig = 1;
        @(negedge clk);
        hw_trig = 0;
    endtask

    task automatic wr_en(input logic v);
        en_wr = 1; en_wdata = v;
        @(negedge clk);
        en_wr = 0;
    endtask

    task automatic wr_start(input logic v);
        start_wr = 1; start_wdata = v;
        @(negedge clk);
        start_wr = 0;
    endtask

    task automatic wr_grp(input logic v);
        grp_wr = 1; grp_wdata = v;
        @(negedge clk);
        grp_wr = 0;
    endtask

    task automatic to_start(output int n);
        n = 1;
        while (!eng_start && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_irqs(input int k);
        int c = 0;
        int guard = 0;
        while (c < k && guard < 500) begin
            @(negedge clk);
            guard++;
            if (irq) c++;
        end
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(enable == 0 && busy == 0 && group == 0, "R1 control bits", {enable, busy, group}, 0);
        chk(result == 0 && irq == 0, "R1 result/irq", int'(result), 0);
        chk(eng_start == 0 && eng_cancel == 0, "R1 engine handshake", {eng_start, eng_cancel}, 0);
    endtask

    task automatic t_disabled();
        int starts = 0;
        clear_log();
        pulse_trig();
        wr_start(1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (eng_start || busy) starts++;
        end
        chk(starts == 0, "R2 ignored while disabled", starts, 0);
        chk(log_n == 0, "R2 no results", log_n, 0);
    endtask

    task automatic t_enable_wait();
        int starts = 0;
        en_wr = 1; en_wdata = 1; hw_trig = 1;
        @(negedge clk);
        en_wr = 0; hw_trig = 0;
        chk(enable == 1, "R3 enable set", enable, 1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (eng_start || busy) starts++;
        end
        chk(starts == 0, "R3 standby until trigger", starts, 0);
    endtask

    task automatic t_full_scan();
        int n;
        clear_log();
        pulse_trig();
        chk(busy == 1, "R4 busy after trigger", busy, 1);
        to_start(n);
        chk(n == SET + 1, "R4 settle latency", n, SET + 1);
        wait_idle();
        expect_log("R5 R6 group 0 scan", 4, '{0, 1, 2, 3, 0, 0, 0, 0});
        chk(busy == 0, "R7 busy clears after scan", busy, 0);
        clear_log();
        pulse_trig();
        wait_idle();
        expect_log("R7 second scan", 4, '{0, 1, 2, 3, 0, 0, 0, 0});
    endtask

    task automatic t_start_launch();
        int n;
        clear_log();
        wr_grp(1);
        chk(busy == 0 && group == 1, "R9 idle group write", {busy, group}, 1);
        wr_start(1);
        to_start(n);
        chk(n == SET + 1, "R10 start write launch latency", n, SET + 1);
        wait_idle();
        expect_log("R5 R10 group 1 scan", 4, '{4, 5, 6, 7, 0, 0, 0, 0});
    endtask

    task automatic t_trig_restart();
        int n;
        wr_grp(0);
        clear_log();
        pulse_trig();
        wait_irqs(2);
        @(negedge clk);
        pulse_trig();
        chk(eng_cancel == 1, "R8 cancel after restart", eng_cancel, 1);
        to_start(n);
        chk(n == SET + 1, "R8 fresh settle on restart", n, SET + 1);
        wait_idle();
        expect_log("R8 trigger restart", 6, '{0, 1, 0, 1, 2, 3, 0, 0});
    endtask

    task automatic t_group_restart();
        clear_log();
        pulse_trig();
        wait_irqs(1);
        @(negedge clk);
        wr_grp(1);
        wait_idle();
        expect_log("R9 group change restart", 5, '{0, 4, 5, 6, 7, 0, 0, 0});
        clear_log();
        pulse_trig();
        wait_irqs(2);
        @(negedge clk);
        wr_grp(1);
        wait_idle();
        expect_log("R9 same group rewrite", 6, '{4, 5, 4, 5, 6, 7, 0, 0});
    endtask

    task automatic t_start1_restart();
        wr_grp(0);
        clear_log();
        pulse_trig();
        wait_irqs(3);
        @(negedge clk);
        wr_start(1);
        wait_idle();
        expect_log("R10 start rewrite restart", 7, '{0, 1, 2, 0, 1, 2, 3, 0});
    endtask

    task automatic t_stop();
        clear_log();
        pulse_trig();
        wait_irqs(1);
        @(negedge clk);
        wr_start(0);
        chk(busy == 0, "R11 busy cleared by stop", busy, 1'b0);
        chk(eng_cancel == 1, "R11 cancel on stop", eng_cancel, 1);
        repeat (30) @(negedge clk);
        chk(log_n == 1, "R11 no result after stop", log_n, 1);
        clear_log();
        pulse_trig();
        wait_idle();
        expect_log("R11 trigger after stop", 4, '{0, 1, 2, 3, 0, 0, 0, 0});
    endtask

    task automatic t_priority();
        clear_log();
        pulse_trig();
        wait_irqs(1);
        repeat (LAT) @(negedge clk);
        pulse_trig();
        wait_idle();
        expect_log("R13 done discarded on restart", 5, '{0, 0, 1, 2, 3, 0, 0, 0});
        clear_log();
        pulse_trig();
        repeat (2) @(negedge clk);
        start_wr = 1; start_wdata = 0; hw_trig = 1;
        @(negedge clk);
        start_wr = 0; hw_trig = 0;
        chk(busy == 0, "R13 stop beats trigger", busy, 0);
    endtask

    task automatic t_disable_abort();
        clear_log();
        pulse_trig();
        wait_irqs(1);
        @(negedge clk);
        wr_en(0);
        chk(enable == 0 && busy == 0, "R12 disable aborts", {enable, busy}, 0);
        pulse_trig();
        repeat (30) @(negedge clk);
        chk(busy == 0 && log_n == 1, "R12 trigger ignored after disable", log_n, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_enable_wait();
        t_full_scan();
        t_start_launch();
        t_trig_restart();
        t_group_restart();
        t_start1_restart();
        t_stop();
        t_priority();
        t_disable_abort();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule